// File: doc/BRIEF.md
# DAC Update Pacer with Shadowed Sample

This block paces sample updates for a digital-to-analog converter. Software reaches it through three registers on a simple register bus: the live sample, a small control word and a 16-bit reload value. An internal 16-bit down counter runs while counting is enabled. Software can neither read nor write the counter. Each time the counter expires, it reloads from the reload register and raises a request flag. The flag can drive a DMA controller, which refills the sample.

When shadowing is switched on while the counter runs, sample writes land in a hidden pre-buffer. The pre-buffer is copied to the live sample on the next expiry, so the converter output changes on exact counter boundaries and not when the bus write happens. When shadowing is off, a sample write reaches the output on the next clock edge. Any write to the sample register clears the request flag. The request reaches the DMA output only when DMA is enabled, and DMA is disabled after reset.

Top module: `dacPacer`

## Requirements
- R1: After reset, the sample, control and reload registers read 0, `dacSample` is 0 and `dmaReq` is 0.
- R2: A write that sets the counter-enable bit (control bit 2) at clock edge E0 loads the counter from the reload value N at E1. The request flag (control bit 0) is first set at edge E(N+2), and a timeout then follows every N+1 edges. With N = 0 there is a timeout on every enabled edge.
- R3: Any write to the sample register (offset 0x0) clears the request flag at its edge. If a timeout falls on the same edge, the flag stays set.
- R4: With shadowing inactive, a sample write appears on `dacSample` and in the sample read-back right after its edge.
- R5: Shadowing is active only when both the shadow-enable bit (control bit 1) and counter enable are set. While it is active, sample writes go to a pre-buffer and leave `dacSample` unchanged until the next timeout edge, where `dacSample` takes the pre-buffer value.
- R6: `dmaReq` equals the request flag when the DMA-enable bit (control bit 3) is set, and is 0 when that bit is clear.
- R7: The control word reads back {bits 31:4 = 0, DMA enable, counter enable, shadow enable, request flag}. Writes to bit 0 and to bits 31:4 have no effect.
- R8: Clearing counter enable freezes the counter, and no timeout occurs while it is clear. Setting it again restarts the count from the reload value, with the timing of R2, and does not resume the frozen count.
- R9: The register offsets are 0x0 for the sample, 0x4 for control and 0x8 for reload. The reload register reads back its written value. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte address of the register |
| regWrEn | input | 1 | Write strobe, sampled at the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| dacSample | output | 16 | Live sample driven to the converter |
| dmaReq | output | 1 | Request to the DMA controller |

## Verification
Register writes take effect at the edge that samples them, and reads are combinational. The bench therefore drives inputs on falling edges and checks register state at the next falling edge. Timeouts are checked by counting edges from the write that enabled the counter. The flag must stay low through edge N+1 and be high at edge N+2, and the following expiry must come exactly N+1 edges after the one before. Shadowed samples are checked on every falling edge until the expiry, where `dacSample` must change in the same cycle that the flag rises. The frozen-counter check relies on the restart reaching its timeout after the full N+2 edges. A resumed count would reach it earlier.

// File: rtl/dacPacerPkg.sv
package dacPacerPkg;

  // Byte offsets of the three registers
  localparam int OFS_SAMPLE = 'h0;
  localparam int OFS_CTRL   = 'h4;
  localparam int OFS_RELOAD = 'h8;

  // Control word bit positions
  localparam int BIT_REQ   = 0;
  localparam int BIT_SHADOW = 1;
  localparam int BIT_RUN   = 2;
  localparam int BIT_DMA   = 3;
  localparam int CTRL_W    = 4;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic wrLive;    // sample write straight into the live register
    logic wrPre;     // sample write into the pre-buffer
    logic wrReload;  // reload register write
    logic cntLoad;   // load counter from reload value
    logic cntDec;    // decrement counter
    logic xfer;      // copy pre-buffer into live register
  } dpStrobeT;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_SAMPLE,
    RD_CTRL,
    RD_RELOAD
  } rdSelT;

endpackage

// File: rtl/dacPacerCtrl.sv
module dacPacerCtrl
  import dacPacerPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [CTRL_W-2:0]   cfgWr,     // write data bits 3:1
  input  logic                cntZero,
  output dpStrobeT            strobe,
  output logic [CTRL_W-1:0]   ctrlBits,
  output rdSelT               rdSel,
  output logic                dmaReq
);

  logic hitSample, hitCtrl, hitReload;
  logic wrSample, wrCtrl;
  logic shadowEn, runEn, dmaEn;
  logic runPrev;
  logic reqFlag;
  logic tick, startLoad, shadowActive;

  // Address decode
  always_comb begin
    hitSample = (regAddr == ADDR_W'(OFS_SAMPLE));
    hitCtrl   = (regAddr == ADDR_W'(OFS_CTRL));
    hitReload = (regAddr == ADDR_W'(OFS_RELOAD));
    wrSample  = regWrEn && hitSample;
    wrCtrl    = regWrEn && hitCtrl;
  end

  always_comb begin
    if (hitSample)      rdSel = RD_SAMPLE;
    else if (hitCtrl)   rdSel = RD_CTRL;
    else if (hitReload) rdSel = RD_RELOAD;
    else                rdSel = RD_NONE;
  end

  // Control bits; bit 0 belongs to hardware
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowEn <= 1'b0;
      runEn    <= 1'b0;
      dmaEn    <= 1'b0;
    end else if (wrCtrl) begin
      shadowEn <= cfgWr[BIT_SHADOW-1];
      runEn    <= cfgWr[BIT_RUN-1];
      dmaEn    <= cfgWr[BIT_DMA-1];
    end
  end

  // Remember the previous enable to detect a restart
  always_ff @(posedge clk) begin
    if (!rstN) runPrev <= 1'b0;
    else       runPrev <= runEn;
  end

  always_comb begin
    startLoad    = runEn && !runPrev;
    tick         = runEn && runPrev && cntZero;
    shadowActive = shadowEn && runEn;
  end

  always_comb begin
    strobe          = '0;
    strobe.wrLive   = wrSample && !shadowActive;
    strobe.wrPre    = wrSample && shadowActive;
    strobe.wrReload = regWrEn && hitReload;
    strobe.cntLoad  = startLoad || tick;
    strobe.cntDec   = runEn && runPrev && !cntZero;
    strobe.xfer     = tick && shadowActive;
  end

  // Request flag: a timeout wins over a clearing write
  always_ff @(posedge clk) begin
    if (!rstN)         reqFlag <= 1'b0;
    else if (tick)     reqFlag <= 1'b1;
    else if (wrSample) reqFlag <= 1'b0;
  end

  always_comb begin
    dmaReq   = reqFlag && dmaEn;
    ctrlBits = '0;
    ctrlBits[BIT_REQ]    = reqFlag;
    ctrlBits[BIT_SHADOW] = shadowEn;
    ctrlBits[BIT_RUN]    = runEn;
    ctrlBits[BIT_DMA]    = dmaEn;
  end

  AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> reqFlag); // R2

  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrSample && !tick) |=> !reqFlag); // R3

  AST_DMA_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEn && !(wrCtrl && cfgWr[BIT_DMA-1])) |=> !dmaReq); // R6

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !(wrCtrl && cfgWr[BIT_RUN-1])) |=> !tick); // R8

endmodule

// File: rtl/dacPacerDp.sv
module dacPacerDp
  import dacPacerPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              cntZero,
  output logic [DATA_W-1:0] liveQ,
  output logic [DATA_W-1:0] reloadQ
);

  logic [DATA_W-1:0] preQ;
  logic [DATA_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)                reloadQ <= '0;
    else if (strobe.wrReload) reloadQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             preQ <= '0;
    else if (strobe.wrPre) preQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              liveQ <= '0;
    else if (strobe.wrLive) liveQ <= wrData;
    else if (strobe.xfer)   liveQ <= preQ;
  end

  // Hidden down counter
  always_ff @(posedge clk) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.cntLoad) cntQ <= reloadQ;
    else if (strobe.cntDec)  cntQ <= cntQ - 1'b1;
  end

  assign cntZero = (cntQ == '0);

  AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |=> (liveQ == $past(preQ))); // R5

  AST_PRE_HOLDS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPre && !strobe.xfer) |=> $stable(liveQ)); // R5

  AST_LOAD_FROM_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> (cntQ == $past(reloadQ))); // R8

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntLoad && !strobe.cntDec) |=> $stable(cntQ)); // R8

endmodule

// File: rtl/dacPacer.sv
module dacPacer
  import dacPacerPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  output logic [DATA_W-1:0] dacSample,
  output logic              dmaReq
);

  dpStrobeT          strobe;
  logic              cntZero;
  logic [CTRL_W-1:0] ctrlBits;
  rdSelT             rdSel;
  logic [DATA_W-1:0] reloadQ;
  logic              unusedWrHi;

  assign unusedWrHi = ^regWrData[BUS_W-1:DATA_W];

  dacPacerCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .cfgWr    (regWrData[CTRL_W-1:1]),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .ctrlBits (ctrlBits),
    .rdSel    (rdSel),
    .dmaReq   (dmaReq)
  );

  dacPacerDp #(.DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData[DATA_W-1:0]),
    .cntZero (cntZero),
    .liveQ   (dacSample),
    .reloadQ (reloadQ)
  );

  always_comb begin
    case (rdSel)
      RD_SAMPLE: regRdData = BUS_W'(dacSample);
      RD_CTRL:   regRdData = BUS_W'(ctrlBits);
      RD_RELOAD: regRdData = BUS_W'(reloadQ);
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: tb/test_dacPacer.sv
`timescale 1ns/1ps
module test_dacPacer;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [15:0] dacSample;
  logic        dmaReq;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dacPacer i_dacPacer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .dacSample(dacSample), .dmaReq(dmaReq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Called on a falling edge; the write is taken at the next rising edge
  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic flagIs(input string req, input string what, input logic exp);
    logic [31:0] v;
    rdReg(4'h4, v);
    chk(req, what, {31'b0, v[0]}, {31'b0, exp});
  endtask

  task automatic testReset;
    logic [31:0] v;
    rdReg(4'h0, v); chk("R1", "sample reg", v, 0);
    rdReg(4'h4, v); chk("R1", "ctrl reg", v, 0);
    rdReg(4'h8, v); chk("R1", "reload reg", v, 0);
    chk("R1", "dacSample", {16'b0, dacSample}, 0);
    chk("R1", "dmaReq", {31'b0, dmaReq}, 0);
  endtask

  task automatic testRegMap;
    logic [31:0] v;
    wrReg(4'h8, 32'hABCD_1234);
    rdReg(4'h8, v); chk("R9", "reload readback", v, 32'h1234);
    wrReg(4'h4, 32'hFFFF_FFF0);
    rdReg(4'h4, v); chk("R7", "reserved ctrl bits", v, 0);
    wrReg(4'h4, 32'h3);
    rdReg(4'h4, v); chk("R7", "flag bit not writable", v, 32'h2);
    wrReg(4'h4, 32'h0);
    wrReg(4'hC, 32'hFFFF_FFFF);
    rdReg(4'hC, v); chk("R9", "unmapped read", v, 0);
    rdReg(4'h8, v); chk("R9", "reload after unmapped write", v, 32'h1234);
    rdReg(4'h4, v); chk("R9", "ctrl after unmapped write", v, 0);
    chk("R9", "sample after unmapped write", {16'b0, dacSample}, 0);
  endtask

  task automatic testDirect;
    logic [31:0] v;
    wrReg(4'h0, 32'h0000_BEEF);
    chk("R4", "dacSample direct", {16'b0, dacSample}, 32'hBEEF);
    rdReg(4'h0, v); chk("R4", "sample readback", v, 32'hBEEF);
    // shadow enable without counter: still direct
    wrReg(4'h4, 32'h2);
    wrReg(4'h0, 32'h0000_3333);
    chk("R5", "shadow inactive without counter", {16'b0, dacSample}, 32'h3333);
    wrReg(4'h4, 32'h0);
  endtask

  task automatic testPeriod;
    localparam int N = 3;
    wrReg(4'h8, N);
    wrReg(4'h4, 32'h4);
    flagIs("R2", "flag at E0", 1'b0);
    for (int i = 1; i <= N + 1; i++) begin
      @(negedge clk); flagIs("R2", "flag before first timeout", 1'b0);
    end
    @(negedge clk); flagIs("R2", "flag at E(N+2)", 1'b1);
    chk("R6", "dmaReq blocked", {31'b0, dmaReq}, 0);
    wrReg(4'h0, 32'h0000_0101);
    flagIs("R3", "flag cleared by sample write", 1'b0);
    for (int i = 1; i <= N - 1; i++) begin
      @(negedge clk); flagIs("R2", "flag within period", 1'b0);
    end
    @(negedge clk); flagIs("R2", "flag after N+1 edges", 1'b1);
    wrReg(4'h4, 32'hC);
    chk("R6", "dmaReq passes flag", {31'b0, dmaReq}, 1);
    wrReg(4'h0, 32'h0000_0202);
    chk("R6", "dmaReq after clear", {31'b0, dmaReq}, 0);
    wrReg(4'h4, 32'h0);
    repeat (N + 3) @(negedge clk);
    flagIs("R8", "no timeout while disabled", 1'b0);
  endtask

  task automatic testZeroReload;
    wrReg(4'h8, 0);
    wrReg(4'h4, 32'h4);
    flagIs("R2", "zero reload E0", 1'b0);
    @(negedge clk); flagIs("R2", "zero reload E1", 1'b0);
    @(negedge clk); flagIs("R2", "zero reload E2", 1'b1);
    wrReg(4'h0, 32'h0000_0404);
    flagIs("R3", "timeout beats clearing write", 1'b1);
    wrReg(4'h4, 32'h0);
    wrReg(4'h0, 32'h0000_0505);
    flagIs("R3", "clear when idle", 1'b0);
  endtask

  task automatic testFreeze;
    localparam int N = 5;
    wrReg(4'h8, N);
    wrReg(4'h0, 32'h0);
    wrReg(4'h4, 32'h4);
    repeat (3) @(negedge clk);
    wrReg(4'h4, 32'h0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); flagIs("R8", "frozen counter", 1'b0);
    end
    wrReg(4'h4, 32'h4);
    flagIs("R8", "restart E0", 1'b0);
    for (int i = 1; i <= N + 1; i++) begin
      @(negedge clk); flagIs("R8", "restart reloads, no early timeout", 1'b0);
    end
    @(negedge clk); flagIs("R8", "restart timeout at E(N+2)", 1'b1);
    wrReg(4'h4, 32'h0);
    wrReg(4'h0, 32'h0);
  endtask

  task automatic testShadow;
    localparam int N = 4;
    logic [31:0] v;
    wrReg(4'h8, N);
    wrReg(4'h0, 32'h0000_1111);
    wrReg(4'h4, 32'h6);
    wrReg(4'h0, 32'h0000_2222);
    chk("R5", "live held after shadow write", {16'b0, dacSample}, 32'h1111);
    flagIs("R5", "no timeout yet", 1'b0);
    for (int i = 2; i <= N + 1; i++) begin
      @(negedge clk);
      chk("R5", "live held before timeout", {16'b0, dacSample}, 32'h1111);
    end
    @(negedge clk);
    chk("R5", "live updated at timeout", {16'b0, dacSample}, 32'h2222);
    flagIs("R5", "flag with transfer", 1'b1);
    rdReg(4'h0, v); chk("R5", "sample readback after transfer", v, 32'h2222);
    wrReg(4'h4, 32'h0);
  endtask

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMap();
    testDirect();
    testPeriod();
    testZeroReload();
    testFreeze();
    testShadow();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule